// File: doc/BRIEF.md
# Prioritised Interrupt Level Controller

The controller gathers a set of interrupt request lines. Each line is programmed through a single write port with three settings: a level from 0 to 7, a priority inside that level from 0 to 7, and a vector number. Every cycle it finds the strongest eligible request. Higher level beats lower level, and at equal level the higher priority wins. It then drives that level to the processor as a three-bit interrupt priority level.

A request at levels 1 to 6 follows its line and can be masked. It is eligible only when its level is strictly above the three-bit mask field that the processor holds in bits [10:8] of its status register. Level 7 cannot be masked. A level-7 source is edge-triggered: a rising transition of its line makes it pending, and the pending state is held until that source is acknowledged.

To service a request, the processor raises an acknowledge together with the level it is taking. The controller answers with the vector of the strongest active source at that level and sends a one-cycle pulse to that source. It also drops its level output for one cycle. When no source matches, it answers with the spurious vector 24.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Among eligible sources the highest level wins. `ipl_out` carries that level one clock after the request inputs settle.
- R2: A level-7 request drives `ipl_out` to 7 for every value of `cpu_mask`, including 7.
- R3: A source at levels 1 to 6 is eligible only while its level is strictly greater than `cpu_mask`. `cpu_mask` holds status register bits [10:8], so status value 0x2500 gives mask 5.
- R4: When several sources share the winning level, the one with the higher priority value (0 to 7) wins.
- R5: When level and priority are both equal, the source with the lower index wins.
- R6: A source programmed with level 0 never wins, whatever its request line does.
- R7: A level-7 source becomes pending only on a 0-to-1 transition of its line. It stays pending until it is acknowledged. A line that stays high after its acknowledge does not request again.
- R8: An acknowledge at level L makes `ack_vec` equal to the vector of the winning active source at level L, and sets the matching bit of `ack_src`. This happens in the clock after `ack_valid`, and the mask plays no part in it.
- R9: In the clock after an acknowledge, `ipl_out` is 0. After that it follows the requests again.
- R10: With no eligible request, `ipl_out` is 0. An acknowledge with no active source at the requested level returns vector 24 with `ack_src` all zero.
- R11: After reset, `ipl_out`, `ack_strobe` and `ack_src` are 0 and every source is at level 0. A configuration write takes effect on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the source settings |
| cfg_idx | input | IDX_W | Source being written |
| cfg_level | input | 3 | Level to store (0 disables) |
| cfg_prio | input | 3 | Priority inside the level |
| cfg_vec | input | VEC_W | Vector number to store |
| irq_req | input | NSRC | Request line per source |
| cpu_mask | input | 3 | Mask field of the status register (bits [10:8]) |
| ack_valid | input | 1 | Acknowledge request from the processor |
| ack_level | input | 3 | Level being acknowledged |
| ipl_out | output | 3 | Level presented to the processor, 0 when none |
| ack_strobe | output | 1 | One-cycle pulse marking a valid `ack_vec` |
| ack_vec | output | VEC_W | Vector returned for the last acknowledge |
| ack_src | output | NSRC | One-hot acknowledge pulse to the serviced source |

## Verification
A change on a maskable request line or on `cpu_mask` appears on `ipl_out` one clock later. A rising edge on a level-7 line takes two clocks, because the line goes through the edge register before the output register. A configuration write adds one more clock. The acknowledge results (`ack_vec`, `ack_src`, `ack_strobe`) and the one-cycle zero on `ipl_out` all appear in the single clock after `ack_valid`. The bench drives every input on the falling edge and samples on the falling edge after the number of rising edges each path needs. It waits the longer path wherever both apply, and it checks the exact single clock for the timed effects: the blanked output after an acknowledge and the non-retriggering level-7 line.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LVL_W   = 3;
  localparam int PRI_W   = 3;
  localparam int NMI_LVL = 7;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [PRI_W-1:0] pri_t;

  // Maskable levels must strictly exceed the mask; the top level ignores it.
  function automatic logic lvl_eligible(lvl_t lvl, lvl_t mask);
    return (lvl == lvl_t'(NMI_LVL)) || ((lvl != '0) && (lvl > mask));
  endfunction

  // True when candidate a strictly outranks b (ties keep b, the lower index).
  function automatic logic outranks(lvl_t la, pri_t pa, lvl_t lb, pri_t pb);
    return (la > lb) || ((la == lb) && (pa > pb));
  endfunction
endpackage

// File: rtl/irqc_cfg_regs.sv
module irqc_cfg_regs
  import irqc_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int VEC_W = 8,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  lvl_t                        wr_lvl,
  input  pri_t                        wr_pri,
  input  logic [VEC_W-1:0]            wr_vec,
  output lvl_t [NSRC-1:0]             lvl_o,
  output pri_t [NSRC-1:0]             pri_o,
  output logic [NSRC-1:0][VEC_W-1:0]  vec_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_o[i] <= '0;
        pri_o[i] <= '0;
        vec_o[i] <= '0;
      end else if (hit) begin
        lvl_o[i] <= wr_lvl;
        pri_o[i] <= wr_pri;
        vec_o[i] <= wr_vec;
      end
    end
  end
endmodule

// File: rtl/irqc_req_cond.sv
module irqc_req_cond
  import irqc_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  irq_req,
  input  lvl_t [NSRC-1:0]  lvl,
  input  logic [NSRC-1:0]  clr,
  output logic [NSRC-1:0]  active
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic req_q, pend, nmi_src;
    assign nmi_src = (lvl[i] == lvl_t'(NMI_LVL));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q <= 1'b0;
        pend  <= 1'b0;
      end else begin
        req_q <= irq_req[i];
        if (!nmi_src || clr[i])          pend <= 1'b0;
        else if (irq_req[i] && !req_q)   pend <= 1'b1;
      end
    end

    assign active[i] = nmi_src ? pend : ((lvl[i] != '0) && irq_req[i]);

    // R7: a pending top-level request survives until its acknowledge
    a_r7_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && nmi_src && !clr[i] && $stable(lvl[i])) |=> pend);
  end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  cand,
  input  lvl_t [NSRC-1:0]  lvl,
  input  pri_t [NSRC-1:0]  pri,
  output logic             win_valid,
  output logic [IDX_W-1:0] win_idx,
  output lvl_t             win_lvl
);
  pri_t win_pri;

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    win_pri   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && (!win_valid || outranks(lvl[i], pri[i], win_lvl, win_pri))) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_lvl   = lvl[i];
        win_pri   = pri[i];
      end
    end
  end

  // R5/R1: the chosen index must be one of the candidates
  a_r5_winner_is_cand: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> cand[win_idx]);
  // R10: no winner only when nothing is requesting
  a_r10_none_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |-> (cand == '0));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NSRC     = 8,
  parameter int VEC_W    = 8,
  parameter int SPUR_VEC = 24,
  parameter int IDX_W    = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [2:0]       cfg_level,
  input  logic [2:0]       cfg_prio,
  input  logic [VEC_W-1:0] cfg_vec,
  input  logic [NSRC-1:0]  irq_req,
  input  logic [2:0]       cpu_mask,
  input  logic             ack_valid,
  input  logic [2:0]       ack_level,
  output logic [2:0]       ipl_out,
  output logic             ack_strobe,
  output logic [VEC_W-1:0] ack_vec,
  output logic [NSRC-1:0]  ack_src
);
  lvl_t [NSRC-1:0]            src_lvl;
  pri_t [NSRC-1:0]            src_pri;
  logic [NSRC-1:0][VEC_W-1:0] src_vec;
  logic [NSRC-1:0]            active, elig, at_ack_lvl, ack_clr;
  logic                       pres_valid, svc_valid;
  logic [IDX_W-1:0]           pres_idx, svc_idx;
  lvl_t                       pres_lvl, svc_lvl;
  logic [NSRC-1:0]            svc_onehot;

  irqc_cfg_regs #(.NSRC(NSRC), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_idx),
    .wr_lvl(cfg_level), .wr_pri(cfg_prio), .wr_vec(cfg_vec),
    .lvl_o(src_lvl), .pri_o(src_pri), .vec_o(src_vec));

  irqc_req_cond #(.NSRC(NSRC)) u_cond (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .lvl(src_lvl),
    .clr(ack_clr), .active(active));

  for (genvar i = 0; i < NSRC; i++) begin : g_filt
    assign elig[i]       = active[i] && lvl_eligible(src_lvl[i], cpu_mask);
    assign at_ack_lvl[i] = active[i] && (src_lvl[i] == ack_level);
  end

  // Presentation arbiter: masked view of the requests
  irqc_arbiter #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb_pres (
    .clk(clk), .rst_n(rst_n), .cand(elig), .lvl(src_lvl), .pri(src_pri),
    .win_valid(pres_valid), .win_idx(pres_idx), .win_lvl(pres_lvl));

  // Service arbiter: the level named by the acknowledge
  irqc_arbiter #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb_svc (
    .clk(clk), .rst_n(rst_n), .cand(at_ack_lvl), .lvl(src_lvl), .pri(src_pri),
    .win_valid(svc_valid), .win_idx(svc_idx), .win_lvl(svc_lvl));

  assign svc_onehot = svc_valid ? (NSRC'(1) << svc_idx) : '0;
  assign ack_clr    = ack_valid ? svc_onehot : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ipl_out    <= '0;
      ack_strobe <= 1'b0;
      ack_vec    <= VEC_W'(SPUR_VEC);
      ack_src    <= '0;
    end else begin
      ipl_out    <= (ack_valid || !pres_valid) ? '0 : pres_lvl;
      ack_strobe <= ack_valid;
      ack_src    <= ack_clr;
      if (ack_valid)
        ack_vec  <= svc_valid ? src_vec[svc_idx] : VEC_W'(SPUR_VEC);
    end
  end

  // R3: a maskable level on the output lay above the mask of the cycle before
  a_r3_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (ipl_out != 3'd0 && ipl_out != 3'd7) |-> (ipl_out > $past(cpu_mask)));
  // R2: a top-level winner reaches the output whatever the mask
  a_r2_nmi_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (pres_valid && pres_lvl == 3'd7 && !ack_valid) |=> (ipl_out == 3'd7));
  // R9: output blanked right after an acknowledge
  a_r9_blank_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> (ipl_out == 3'd0));
  // R8: the serviced source sits at the acknowledged level, one at a time
  a_r8_svc_level: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> (svc_lvl == ack_level));
  a_r8_src_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_src) && (ack_src == '0 || ack_strobe));
  // R10: no serviced source means the spurious vector
  a_r10_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_strobe && ack_src == '0) |-> (ack_vec == VEC_W'(SPUR_VEC)));
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int NSRC = 8;
  localparam int VW   = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [2:0]      cfg_idx = '0;
  logic [2:0]      cfg_level = '0, cfg_prio = '0;
  logic [VW-1:0]   cfg_vec = '0;
  logic [NSRC-1:0] irq_req = '0;
  logic [2:0]      cpu_mask = '0;
  logic            ack_valid = 1'b0;
  logic [2:0]      ack_level = '0;
  logic [2:0]      ipl_out;
  logic            ack_strobe;
  logic [VW-1:0]   ack_vec;
  logic [NSRC-1:0] ack_src;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_level(cfg_level), .cfg_prio(cfg_prio), .cfg_vec(cfg_vec),
    .irq_req(irq_req), .cpu_mask(cpu_mask), .ack_valid(ack_valid),
    .ack_level(ack_level), .ipl_out(ipl_out), .ack_strobe(ack_strobe),
    .ack_vec(ack_vec), .ack_src(ack_src));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  // status register value to its mask field (bits 10:8)
  function automatic logic [2:0] sr_mask(logic [15:0] sr);
    return sr[10:8];
  endfunction

  task automatic wr(int idx, int lvl, int pri, int vec);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_level = 3'(lvl);
    cfg_prio = 3'(pri); cfg_vec = VW'(vec);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // acknowledge at a level; results are due in the very next clock
  task automatic do_ack(int lvl);
    ack_valid = 1'b1; ack_level = 3'(lvl);
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 reset ipl", ipl_out, 0);
    check("R11 reset strobe", ack_strobe, 0);
    check("R11 reset src", ack_src, 0);
    irq_req = 8'hFF; settle(2);
    check("R11 all sources at level 0 after reset", ipl_out, 0);
    irq_req = '0; settle(1);
  endtask

  task automatic t_spurious_idle();
    do_ack(3);
    check("R10 spurious vector", ack_vec, 24);
    check("R10 spurious no src", ack_src, 0);
    check("R10 strobe", ack_strobe, 1);
  endtask

  task automatic t_level0();
    wr(6, 0, 7, 8'h66);
    irq_req[6] = 1'b1; settle(2);
    check("R6 level0 source ignored", ipl_out, 0);
    wr(6, 4, 0, 8'h66); settle(1);
    check("R11 write takes effect", ipl_out, 4);
    irq_req[6] = 1'b0; settle(1);
    check("R10 no request gives 0", ipl_out, 0);
  endtask

  task automatic t_levels();
    cpu_mask = sr_mask(16'h2000);
    irq_req[0] = 1'b1; irq_req[5] = 1'b1; settle(1);
    check("R1 higher level wins", ipl_out, 3);
    do_ack(2);
    check("R8 vector at acked level", ack_vec, 8'h45);
    check("R8 src at acked level", ack_src, 8'h20);
    irq_req = '0; settle(2);
  endtask

  task automatic t_mask();
    irq_req[1] = 1'b1;
    cpu_mask = sr_mask(16'h2500); settle(1);
    check("R3 level equal to mask blocked", ipl_out, 0);
    cpu_mask = sr_mask(16'h2400); settle(1);
    check("R3 level above mask shown", ipl_out, 5);
    cpu_mask = sr_mask(16'h2700); settle(1);
    check("R3 mask 7 blocks level 5", ipl_out, 0);
    irq_req = '0; cpu_mask = '0; settle(2);
  endtask

  task automatic t_prio();
    irq_req[1] = 1'b1; irq_req[2] = 1'b1; settle(2);
    check("R4 level shown", ipl_out, 5);
    do_ack(5);
    check("R4 higher priority vector", ack_vec, 8'h42);
    check("R4 higher priority src", ack_src, 8'h04);
    check("R9 ipl zero after ack", ipl_out, 0);
    settle(1);
    check("R9 ipl back after blank", ipl_out, 5);
    check("R8 src pulse is one cycle", ack_src, 0);
    irq_req = '0; settle(2);
  endtask

  task automatic t_tie();
    irq_req[2] = 1'b1; irq_req[3] = 1'b1; settle(2);
    do_ack(5);
    check("R5 lower index wins tie", ack_vec, 8'h42);
    irq_req[2] = 1'b0; settle(2);
    do_ack(5);
    check("R5 remaining source served", ack_vec, 8'h43);
    check("R5 remaining src", ack_src, 8'h08);
    do_ack(4);
    check("R10 ack at empty level spurious", ack_vec, 24);
    irq_req = '0; settle(2);
  endtask

  task automatic t_nmi();
    cpu_mask = sr_mask(16'h2700);
    irq_req[1] = 1'b1;
    irq_req[4] = 1'b1; settle(2);
    check("R2 level 7 ignores mask 7", ipl_out, 7);
    do_ack(7);
    check("R8 nmi vector", ack_vec, 8'h44);
    check("R8 nmi src", ack_src, 8'h10);
    settle(1);
    check("R7 held line does not retrigger", ipl_out, 0);
    settle(3);
    check("R7 still quiet while high", ipl_out, 0);
    irq_req[4] = 1'b0; settle(2);
    irq_req[4] = 1'b1; settle(2);
    check("R7 fresh edge requests again", ipl_out, 7);
    irq_req[4] = 1'b0; settle(3);
    check("R7 pending held after line drops", ipl_out, 7);
    do_ack(7);
    settle(1);
    check("R7 cleared by ack", ipl_out, 0);
    irq_req = '0; cpu_mask = '0; settle(2);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(1);
    t_reset();
    t_spurious_idle();
    t_level0();
    wr(0, 3, 2, 8'h40);
    wr(1, 5, 1, 8'h41);
    wr(2, 5, 6, 8'h42);
    wr(3, 5, 6, 8'h43);
    wr(4, 7, 0, 8'h44);
    wr(5, 2, 0, 8'h45);
    wr(6, 0, 0, 8'h66);
    settle(2);
    t_levels();
    t_mask();
    t_prio();
    t_tie();
    t_nmi();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule